// File: doc/BRIEF.md
# Dual-Channel Triggered Wave Generator

This block is the digital path that feeds a two-channel 12-bit converter. Each channel keeps a holding value, loaded for both channels at once through a shared write port that takes the data right-aligned, left-aligned or as 8-bit values. Each channel picks one of eight trigger lines and can be enabled or disabled for triggering on its own. When a trigger is accepted, the channel adds a wave term to its holding value. The wave term is zero, a masked pseudo-random noise word or a triangle counter. The sum reaches the channel output exactly three clocks later.

The noise and triangle counters advance only on the edge that transfers the sum. The next conversion therefore uses the new counter value. When both channels select the same trigger line they convert together, and each keeps its own wave mode and its own mask or amplitude. A trigger that arrives while a conversion is still in flight is dropped.

Top module: `dacw_dual_wave`

## Requirements
- R1: When `hold_wr` is high at a rising edge, the holding values are loaded according to `hold_fmt`. With code 0, ch0 takes `hold_wdata[11:0]` and ch1 takes `hold_wdata[27:16]`. With code 1, ch0 takes `hold_wdata[15:4]` and ch1 takes `hold_wdata[31:20]`. With code 2, ch0 takes `{hold_wdata[7:0],4'h0}` and ch1 takes `{hold_wdata[15:8],4'h0}`. Code 3 writes nothing.
- R2: A channel whose `ch_trig_en` bit is low ignores every trigger. Its output and its wave counters stay unchanged.
- R3: A channel reacts only to the line `trig_in[ch_trig_sel]`. When both channels select the same line, one pulse updates both outputs on the same edge.
- R4: With wave code 00 the output after a trigger equals the holding value.
- R5: When a trigger is sampled at rising edge k, the output takes the new value at edge k+3 and stays unchanged at edges k+1 and k+2.
- R6: With wave code 01 the output is (hold + (lfsr & M)) mod 4096. M keeps bits [n:0] where n is the channel's `ch_amp`, and M is all 12 bits when n ≥ 11. The 12-bit LFSR resets to 0xAAA and steps as lfsr ← {lfsr[10:0], lfsr[11]^lfsr[10]^lfsr[7]^lfsr[5]}.
- R7: With wave code 10 or 11 the output is (hold + t) mod 4096. The triangle counter t resets to 0 and rises by 1 per conversion. When a rising step finds t ≥ P, where P = 2^(min(n,11)+1)−1, the direction flips and t falls by 1. A falling step from t = 0 sets t = 1 and turns rising.
- R8: A wave counter advances only on a transfer edge, and only the counter of the mode selected at that edge advances.
- R9: A trigger sampled at any of the three edges after an accepted trigger, including the transfer edge, is ignored.
- R10: The two channels apply their own `ch_amp` and wave mode even when they share a trigger line.
- R11: After reset both outputs and both holding values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_trig_en | input | 2 | Per-channel trigger enable |
| ch_trig_sel | input | 2x3 | Per-channel trigger line select |
| ch_wave | input | 2x2 | Per-channel wave mode: 00 off, 01 noise, 1x triangle |
| ch_amp | input | 2x4 | Per-channel noise mask width or triangle amplitude |
| trig_in | input | 8 | Trigger lines, sampled high on a rising edge |
| hold_wr | input | 1 | Dual holding-value write strobe |
| hold_fmt | input | 2 | Write format code (see R1) |
| hold_wdata | input | 32 | Dual holding-value write data |
| dac_out | output | 2x12 | Per-channel output register |

## Verification
The assertions assume that wave mode, mask and holding value stay still while a conversion is pending. They also assume that `hold_fmt` is only meaningful when `hold_wr` is high, and that triggers are plain sampled levels. The stimulus changes configuration and holding values only between conversions. It drives every trigger from the falling edge as a pulse of one to four cycles. The longer pulses are how the in-flight drop of R9 is exercised.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

    // Number of channels served by the dual write port.
    localparam int unsigned DACW_NCH = 2;

    typedef enum logic [1:0] {
        FMT_R12  = 2'd0,
        FMT_L12  = 2'd1,
        FMT_R8   = 2'd2,
        FMT_NONE = 2'd3
    } dacw_fmt_e;

    typedef enum logic [1:0] {
        WV_OFF   = 2'd0,
        WV_NOISE = 2'd1,
        WV_TRI   = 2'd2
    } dacw_wave_e;

    // Upper bit set selects triangle; otherwise bit 0 selects noise.
    function automatic dacw_wave_e wave_decode(input logic [1:0] code);
        if (code[1])      return WV_TRI;
        else if (code[0]) return WV_NOISE;
        else              return WV_OFF;
    endfunction

endpackage

// File: rtl/dacw_hold_regs.sv
module dacw_hold_regs
    import dacw_pkg::*;
#(
    parameter int unsigned DW = 12,
    parameter int unsigned HW = 16,
    parameter int unsigned BW = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [1:0]                    fmt,
    input  logic [DACW_NCH*HW-1:0]        wdata,
    output logic [DACW_NCH-1:0][DW-1:0]   hold
);

    localparam int unsigned PADW = DW - BW;

    typedef struct packed {
        logic [DACW_NCH-1:0][DW-1:0] val;
    } hold_st_t;

    hold_st_t                    st_d, st_q;
    logic [DACW_NCH-1:0][DW-1:0] decoded;

    // Per-channel field extraction for the selected format.
    always_comb begin
        for (int c = 0; c < DACW_NCH; c++) begin
            unique case (dacw_fmt_e'(fmt))
                FMT_R12: decoded[c] = wdata[c*HW +: DW];
                FMT_L12: decoded[c] = wdata[c*HW + HW - DW +: DW];
                FMT_R8:  decoded[c] = {wdata[c*BW +: BW], {PADW{1'b0}}};
                default: decoded[c] = st_q.val[c];
            endcase
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr && (dacw_fmt_e'(fmt) != FMT_NONE)) begin
            st_d.val = decoded;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold = st_q.val;

endmodule

// File: rtl/dacw_wave_gen.sv
module dacw_wave_gen
    import dacw_pkg::*;
#(
    parameter int unsigned    DW   = 12,
    parameter int unsigned    AW   = 4,
    parameter logic [DW-1:0]  TAPS = 12'hCA0,
    parameter logic [DW-1:0]  SEED = 12'hAAA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] amp,
    input  logic          step,
    output logic [DW-1:0] wave,
    output logic [DW-1:0] lfsr_cnt,
    output logic [DW-1:0] tri_cnt
);

    localparam int unsigned TOP = DW - 1;

    typedef struct packed {
        logic [DW-1:0] lfsr;
        logic [DW-1:0] tri_v;
        logic          down;
    } wave_st_t;

    wave_st_t      st_d, st_q;
    logic [DW-1:0] span;
    dacw_wave_e    sel_mode;

    // Noise mask and triangle peak share one value: bits [n:0] set.
    always_comb begin
        span = '1;
        if (int'(amp) < int'(TOP)) begin
            span = (DW'(2) << amp) - DW'(1);
        end
    end

    assign sel_mode = wave_decode(mode);

    always_comb begin
        unique case (sel_mode)
            WV_NOISE: wave = st_q.lfsr & span;
            WV_TRI:   wave = st_q.tri_v;
            default:  wave = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (step) begin
            unique case (sel_mode)
                WV_NOISE: begin
                    st_d.lfsr = {st_q.lfsr[DW-2:0], ^(st_q.lfsr & TAPS)};
                end
                WV_TRI: begin
                    if (!st_q.down) begin
                        if (st_q.tri_v >= span) begin
                            st_d.tri_v = st_q.tri_v - DW'(1);
                            st_d.down  = 1'b1;
                        end else begin
                            st_d.tri_v = st_q.tri_v + DW'(1);
                        end
                    end else if (st_q.tri_v == '0) begin
                        st_d.tri_v = DW'(1);
                        st_d.down  = 1'b0;
                    end else begin
                        st_d.tri_v = st_q.tri_v - DW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lfsr  <= SEED;
            st_q.tri_v <= '0;
            st_q.down  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lfsr_cnt = st_q.lfsr;
    assign tri_cnt  = st_q.tri_v;

endmodule

// File: rtl/dacw_chan_pipe.sv
module dacw_chan_pipe #(
    parameter int unsigned DW   = 12,
    parameter int unsigned SELW = 3,
    parameter int unsigned LAT  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [(1<<SELW)-1:0]   trig,
    input  logic                   en,
    input  logic [SELW-1:0]        sel,
    input  logic [DW-1:0]          hold,
    input  logic [DW-1:0]          wave,
    output logic [DW-1:0]          dout,
    output logic                   accept,
    output logic                   busy,
    output logic                   xfer
);

    localparam int unsigned CW = $clog2(LAT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [DW-1:0] sum;
        logic [DW-1:0] out;
    } pipe_st_t;

    pipe_st_t st_d, st_q;

    // cnt == 0 idle, 1..LAT-1 waiting, LAT on the transfer cycle.
    assign busy   = (st_q.cnt != '0);
    assign xfer   = (st_q.cnt == CW'(LAT));
    assign accept = en && trig[sel] && !busy;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.cnt = CW'(1);
            st_d.sum = hold + wave;
        end else if (xfer) begin
            st_d.cnt = '0;
            st_d.out = st_q.sum;
        end else if (busy) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.out;

endmodule

// File: rtl/dacw_dual_wave.sv
module dacw_dual_wave
    import dacw_pkg::*;
#(
    parameter int unsigned   DW        = 12,
    parameter int unsigned   SELW      = 3,
    parameter int unsigned   AW        = 4,
    parameter int unsigned   LAT       = 3,
    parameter int unsigned   HW        = 16,
    parameter int unsigned   BW        = 8,
    parameter logic [DW-1:0] LFSR_TAPS = 12'hCA0,
    parameter logic [DW-1:0] LFSR_SEED = 12'hAAA
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [DACW_NCH-1:0]             ch_trig_en,
    input  logic [DACW_NCH-1:0][SELW-1:0]   ch_trig_sel,
    input  logic [DACW_NCH-1:0][1:0]        ch_wave,
    input  logic [DACW_NCH-1:0][AW-1:0]     ch_amp,
    input  logic [(1<<SELW)-1:0]            trig_in,
    input  logic                            hold_wr,
    input  logic [1:0]                      hold_fmt,
    input  logic [DACW_NCH*HW-1:0]          hold_wdata,
    output logic [DACW_NCH-1:0][DW-1:0]     dac_out
);

    logic [DACW_NCH-1:0][DW-1:0] hold_w;
    logic [DACW_NCH-1:0][DW-1:0] wave_w;
    logic [DACW_NCH-1:0][DW-1:0] lfsr_w;
    logic [DACW_NCH-1:0][DW-1:0] tri_w;
    logic [DACW_NCH-1:0]         accept_w;
    logic [DACW_NCH-1:0]         busy_w;
    logic [DACW_NCH-1:0]         xfer_w;

    dacw_hold_regs #(
        .DW (DW),
        .HW (HW),
        .BW (BW)
    ) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (hold_wr),
        .fmt   (hold_fmt),
        .wdata (hold_wdata),
        .hold  (hold_w)
    );

    for (genvar c = 0; c < DACW_NCH; c++) begin : g_ch
        dacw_wave_gen #(
            .DW   (DW),
            .AW   (AW),
            .TAPS (LFSR_TAPS),
            .SEED (LFSR_SEED)
        ) u_wave (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (ch_wave[c]),
            .amp      (ch_amp[c]),
            .step     (xfer_w[c]),
            .wave     (wave_w[c]),
            .lfsr_cnt (lfsr_w[c]),
            .tri_cnt  (tri_w[c])
        );

        dacw_chan_pipe #(
            .DW   (DW),
            .SELW (SELW),
            .LAT  (LAT)
        ) u_pipe (
            .clk    (clk),
            .rst_n  (rst_n),
            .trig   (trig_in),
            .en     (ch_trig_en[c]),
            .sel    (ch_trig_sel[c]),
            .hold   (hold_w[c]),
            .wave   (wave_w[c]),
            .dout   (dac_out[c]),
            .accept (accept_w[c]),
            .busy   (busy_w[c]),
            .xfer   (xfer_w[c])
        );
    end

endmodule

// File: rtl/dacw_checker.sv
module dacw_checker
    import dacw_pkg::*;
#(
    parameter int unsigned DW = 12
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          hold_wr,
    input logic [1:0]                    hold_fmt,
    input logic [DACW_NCH-1:0][DW-1:0]   hold_q,
    input logic [DACW_NCH-1:0]           accept,
    input logic [DACW_NCH-1:0]           busy,
    input logic [DACW_NCH-1:0]           xfer,
    input logic [DACW_NCH-1:0][DW-1:0]   lfsr_q,
    input logic [DACW_NCH-1:0][DW-1:0]   tri_q,
    input logic [DACW_NCH-1:0][DW-1:0]   dac_out
);

    for (genvar c = 0; c < DACW_NCH; c++) begin : g_chk
        // R1: holding value moves only on a real write
        a_r1_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (!hold_wr || hold_fmt == 2'd3) |=> $stable(hold_q[c]));

        // R5: output register changes only on a transfer edge
        a_r5_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !xfer[c] |=> $stable(dac_out[c]));

        // R9: an accepted trigger opens a pending window
        a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
            accept[c] |=> busy[c]);

        // R9: the window stays open until its transfer
        a_r9_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
            (busy[c] && !xfer[c]) |=> busy[c]);

        // R8: counters frozen outside transfer edges
        a_r8_counters_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !xfer[c] |=> ($stable(lfsr_q[c]) && $stable(tri_q[c])));

        // R6: noise register never collapses to zero
        a_r6_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
            lfsr_q[c] != '0);

        // R7: triangle moves by exactly one per step
        a_r7_tri_unit: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(tri_q[c]) |->
                ((tri_q[c] == $past(tri_q[c]) + DW'(1)) ||
                 (tri_q[c] == $past(tri_q[c]) - DW'(1))));
    end

endmodule

bind dacw_dual_wave dacw_checker #(
    .DW (DW)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_wr  (hold_wr),
    .hold_fmt (hold_fmt),
    .hold_q   (hold_w),
    .accept   (accept_w),
    .busy     (busy_w),
    .xfer     (xfer_w),
    .lfsr_q   (lfsr_w),
    .tri_q    (tri_w),
    .dac_out  (dac_out)
);

// File: tb/dacw_dual_wave_tb_top.sv
module dacw_dual_wave_tb_top;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       en;
    logic [1:0][2:0]  sel;
    logic [1:0][1:0]  wave;
    logic [1:0][3:0]  amp;
    logic [7:0]       trig;
    logic             hwr;
    logic [1:0]       hfmt;
    logic [31:0]      hdata;
    logic [1:0][11:0] dout;

    int checks = 0;
    int errors = 0;

    logic [11:0] m_hold [2];
    logic [11:0] m_lfsr [2];
    logic [11:0] m_tri  [2];
    logic [11:0] m_out  [2];
    bit          m_dn   [2];

    always #10 clk = ~clk;

    dacw_dual_wave dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ch_trig_en  (en),
        .ch_trig_sel (sel),
        .ch_wave     (wave),
        .ch_amp      (amp),
        .trig_in     (trig),
        .hold_wr     (hwr),
        .hold_fmt    (hfmt),
        .hold_wdata  (hdata),
        .dac_out     (dout)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %03h expected %03h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] mask_of(input int n);
        if (n >= 11) return 12'hFFF;
        return (12'h002 << n) - 12'h001;
    endfunction

    function automatic logic [11:0] wave_term(input int c);
        if (wave[c][1])        return m_tri[c];
        if (wave[c] == 2'b01)  return m_lfsr[c] & mask_of(int'(amp[c]));
        return 12'h000;
    endfunction

    task automatic advance(input int c);
        logic [11:0] pk;
        if (wave[c][1]) begin
            pk = mask_of(int'(amp[c]));
            if (!m_dn[c]) begin
                if (m_tri[c] >= pk) begin m_tri[c] = m_tri[c] - 1; m_dn[c] = 1'b1; end
                else m_tri[c] = m_tri[c] + 1;
            end else if (m_tri[c] == 12'h000) begin
                m_tri[c] = 12'h001; m_dn[c] = 1'b0;
            end else begin
                m_tri[c] = m_tri[c] - 1;
            end
        end else if (wave[c] == 2'b01) begin
            m_lfsr[c] = {m_lfsr[c][10:0],
                         m_lfsr[c][11] ^ m_lfsr[c][10] ^ m_lfsr[c][7] ^ m_lfsr[c][5]};
        end
    endtask

    // R1 field placement, computed from the requirement text.
    task automatic write_hold(input logic [1:0] f, input logic [31:0] d);
        @(negedge clk);
        hwr = 1'b1; hfmt = f; hdata = d;
        @(negedge clk);
        hwr = 1'b0;
        case (f)
            2'd0: begin m_hold[0] = d[11:0];  m_hold[1] = d[27:16]; end
            2'd1: begin m_hold[0] = d[15:4];  m_hold[1] = d[31:20]; end
            2'd2: begin m_hold[0] = {d[7:0], 4'h0}; m_hold[1] = {d[15:8], 4'h0}; end
            default: ;
        endcase
    endtask

    // Trigger pulse of 'width' cycles; checks R5 latency and the result.
    task automatic fire(input logic [7:0] tm, input int width, input string req);
        logic [11:0] nxt [2];
        bit          acc [2];
        @(negedge clk);
        for (int c = 0; c < 2; c++) begin
            acc[c] = en[c] && tm[sel[c]];
            nxt[c] = acc[c] ? m_hold[c] + wave_term(c) : m_out[c];
        end
        trig = tm;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (i == width - 1) trig = 8'h00;
            if (i == 2) for (int c = 0; c < 2; c++) chk("R5", dout[c], m_out[c]);
            if (i == 3) for (int c = 0; c < 2; c++) chk(req, dout[c], nxt[c]);
        end
        for (int c = 0; c < 2; c++) begin
            if (acc[c]) advance(c);
            m_out[c] = nxt[c];
        end
    endtask

    initial begin
        en = 2'b00; sel = '0; wave = '0; amp = '0; trig = '0;
        hwr = 1'b0; hfmt = 2'd0; hdata = '0;
        for (int c = 0; c < 2; c++) begin
            m_hold[c] = '0; m_lfsr[c] = 12'hAAA; m_tri[c] = '0; m_out[c] = '0; m_dn[c] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", dout[0], 12'h000);
        chk("R11", dout[1], 12'h000);

        // R1 / R4 / R3: every format, wave off, shared trigger line 0
        en = 2'b11;
        for (int p = 0; p < 4; p++) begin
            for (int f = 0; f < 4; f++) begin
                write_hold(2'(f), 32'h9E37_79B9 * (p + 1) + 32'(f * 7));
                fire(8'h01, 1, (f == 3) ? "R1" : "R4");
            end
        end

        // R3: each line, channels on different lines
        for (int s = 0; s < 8; s++) begin
            sel[0] = 3'(s);
            sel[1] = 3'(7 - s);
            write_hold(2'd0, 32'h0000_0000 + 32'(s * 32'h0111_0123));
            fire(8'(1 << s), 1, "R3");
            fire(8'(1 << (7 - s)), 1, "R3");
        end
        sel[0] = 3'd4; sel[1] = 3'd4;

        // R2: disabled channel ignores trigger, counter untouched
        wave[0] = 2'b01; wave[1] = 2'b10; amp[0] = 4'd11; amp[1] = 4'd3;
        en = 2'b01;
        write_hold(2'd0, 32'h0200_0100);
        fire(8'h10, 1, "R2");
        fire(8'h10, 1, "R2");
        en = 2'b11;
        fire(8'h10, 1, "R2");

        // R6 / R10: noise mask sweep, different masks per channel
        wave[0] = 2'b01; wave[1] = 2'b01;
        for (int n = 0; n < 16; n++) begin
            amp[0] = 4'(n);
            amp[1] = 4'(15 - n);
            write_hold(2'd0, 32'(n * 32'h0111_0111));
            for (int k = 0; k < 3; k++) fire(8'h10, 1, (k == 1) ? "R10" : "R6");
        end
        write_hold(2'd0, 32'h0FFF_0FFF);
        for (int k = 0; k < 4; k++) fire(8'h10, 1, "R6");

        // R7: triangle sweep over small amplitudes, ch1 at another amplitude
        wave[0] = 2'b10; wave[1] = 2'b11;
        write_hold(2'd0, 32'h0100_0040);
        for (int n = 0; n < 6; n++) begin
            amp[0] = 4'(n);
            amp[1] = 4'((n + 2) % 6);
            for (int k = 0; k < (4 << n) + 1; k++) fire(8'h10, 1, "R7");
        end
        amp[0] = 4'd15; amp[1] = 4'd11;
        write_hold(2'd0, 32'h0FF0_0FF8);
        for (int k = 0; k < 24; k++) fire(8'h10, 1, "R7");

        // R8: back to noise; counter resumes where it stopped
        wave[0] = 2'b01; wave[1] = 2'b00; amp[0] = 4'd11;
        for (int k = 0; k < 3; k++) fire(8'h10, 1, "R8");
        wave[0] = 2'b10; wave[1] = 2'b01;
        for (int k = 0; k < 3; k++) fire(8'h10, 1, "R8");

        // R9: long pulses, only the first edge counts
        wave[0] = 2'b01; wave[1] = 2'b10; amp[0] = 4'd7; amp[1] = 4'd2;
        for (int w = 2; w <= 4; w++) begin
            for (int k = 0; k < 3; k++) fire(8'h10, w, "R9");
        end

        summary();
    end

endmodule